// File: doc/BRIEF.md
# Time Base and Decrementer Unit

This block keeps two 64-bit time bases, a primary one and an alternate one, and a 32-bit decrementer that flags an interrupt when it expires. All three counters move only on cycles where the tick-enable input is high and the run-enable input is high. When run-enable is low, all three counters hold their values. They resume from those held values when run-enable returns high.

Software writes through a single write port. A select code picks one of five targets: the lower or upper half of either time base, or the whole decrementer. A half write replaces only its half and leaves the other half unchanged. A write takes priority over counting in the same cycle.

The decrementer has two modes. In wrap mode it passes from zero to all-ones and signals expiry. In hold mode it stops at zero and signals expiry once, on the step from one to zero. Loading a negative value while the current value is non-negative also raises the interrupt. The interrupt is a sticky pending flag that a separate acknowledge input clears.

Top module: `timebase_decr_unit`

## Requirements
- R1: After a synchronous reset both time bases read 0, the decrementer reads 0xFFFFFFFF and the interrupt flag is low.
- R2: On a cycle with tick_en and run_en both high and no write to that counter, each time base increases by one, visible after that clock edge.
- R3: Write select codes are: 0 = primary low half, 1 = primary high half, 2 = alternate low half, 3 = alternate high half, 4 = decrementer. A half write replaces that 32-bit half and keeps the other half. Codes 5 to 7 change nothing.
- R4: While run_en is low, both time bases and the decrementer hold their values whatever tick_en does. When run_en is high again, they count on from the held values.
- R5: A write to a counter in a cycle where it would also count leaves exactly the written data in it, with no count applied.
- R6: In wrap mode (stop_at_zero = 0), a count step at value 0 sets the decrementer to 0xFFFFFFFF and sets the interrupt flag.
- R7: In hold mode (stop_at_zero = 1), a count step at value 1 sets the decrementer to 0 and sets the interrupt flag. Further count steps leave it at 0 and raise no new interrupt.
- R8: With the UNDERFLOW_TRIG parameter at its default of 1, a decrementer write with data bit 31 set, made while the current bit 31 is clear, sets the interrupt flag on the next cycle. A write made while the current bit 31 is already set does not set it.
- R9: The interrupt flag stays set until irq_ack is high. If a new interrupt event occurs in the same cycle as irq_ack, the flag stays set.
- R10: A count step carries from bit 31 into bit 32 of a time base, so 0x00000000FFFFFFFF becomes 0x0000000100000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count strobe |
| run_en | input | 1 | High lets the counters advance; low freezes them |
| stop_at_zero | input | 1 | Decrementer mode: 1 = hold at zero, 0 = wrap |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write target code (see R3) |
| wr_data | input | 32 | Write data |
| irq_ack | input | 1 | Clears the pending interrupt |
| tb_value | output | 64 | Primary time base |
| atb_value | output | 64 | Alternate time base |
| dec_value | output | 32 | Decrementer |
| dec_irq | output | 1 | Sticky decrementer interrupt pending |

## Verification
The bench targets these corner cases:
- Low-half writes at 0xFFFFFFFF followed by a tick. A design with a broken carry leaves the upper half at zero.
- Writes that land on a tick cycle. A design that gives counting priority shows the written value minus or plus one.
- Decrementer expiry in both modes. Wrap mode must show a wrap to all-ones with the flag set. Hold mode must raise the flag exactly once and stay at zero.
- Negative loads both from a non-negative and from an already negative current value. A design that ignores the current sign raises spurious interrupts.
- Acknowledge cycles that coincide with a new event. A design where acknowledge wins loses that event.
- Freeze periods with ticks present and unused select codes. In both cases any changed counter value exposes the fault.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
  localparam int SEL_W = 3;
  typedef enum logic [SEL_W-1:0] {
    SEL_TB_LO  = 3'd0,
    SEL_TB_HI  = 3'd1,
    SEL_ATB_LO = 3'd2,
    SEL_ATB_HI = 3'd3,
    SEL_DEC    = 3'd4
  } wsel_e;
  localparam int NUM_TB = 2;
endpackage

// File: rtl/tbd_timebase.sv
module tbd_timebase #(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wr_data,
  output logic [2*HALF_W-1:0] value
);
  localparam int FULL_W = 2 * HALF_W;

  logic [FULL_W-1:0] nxt;

  always_comb begin
    nxt = value;
    if (wr_lo)
      nxt = {value[FULL_W-1:HALF_W], wr_data};
    else if (wr_hi)
      nxt = {wr_data, value[HALF_W-1:0]};
    else if (adv)
      nxt = value + {{(FULL_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk) begin
    if (rst) value <= '0;
    else     value <= nxt;
  end
endmodule

// File: rtl/tbd_decrementer.sv
module tbd_decrementer #(
  parameter int DATA_W         = 32,
  parameter bit UNDERFLOW_TRIG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              stop_mode,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ack,
  output logic [DATA_W-1:0] value,
  output logic              irq
);
  localparam logic [DATA_W-1:0] ONE  = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] ZERO = '0;

  logic [DATA_W-1:0] nxt;
  logic              evt;

  always_comb begin
    nxt = value;
    evt = 1'b0;
    if (wr) begin
      nxt = wr_data;
      if (UNDERFLOW_TRIG && wr_data[DATA_W-1] && !value[DATA_W-1])
        evt = 1'b1;
    end else if (adv) begin
      if (stop_mode) begin
        if (value != ZERO) nxt = value - ONE;
        if (value == ONE)  evt = 1'b1;
      end else begin
        nxt = value - ONE;
        if (value == ZERO) evt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '1;
      irq   <= 1'b0;
    end else begin
      value <= nxt;
      irq   <= evt | (irq & ~ack);
    end
  end
endmodule

// File: rtl/timebase_decr_unit.sv
module timebase_decr_unit
  import tbd_pkg::*;
#(
  parameter int DATA_W         = 32,
  parameter bit UNDERFLOW_TRIG = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_en,
  input  logic                run_en,
  input  logic                stop_at_zero,
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    wr_sel,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                irq_ack,
  output logic [2*DATA_W-1:0] tb_value,
  output logic [2*DATA_W-1:0] atb_value,
  output logic [DATA_W-1:0]   dec_value,
  output logic                dec_irq
);
  localparam int TB_W = 2 * DATA_W;

  logic            adv;
  logic [TB_W-1:0] tb_q [NUM_TB];

  assign adv = tick_en & run_en;

  for (genvar i = 0; i < NUM_TB; i++) begin : g_tb
    localparam logic [SEL_W-1:0] LO_CODE = SEL_W'(2 * i);
    localparam logic [SEL_W-1:0] HI_CODE = SEL_W'(2 * i + 1);
    tbd_timebase #(.HALF_W(DATA_W)) tb_i (
      .clk     (clk),
      .rst     (rst),
      .adv     (adv),
      .wr_lo   (wr_en && (wr_sel == LO_CODE)),
      .wr_hi   (wr_en && (wr_sel == HI_CODE)),
      .wr_data (wr_data),
      .value   (tb_q[i])
    );
  end

  assign tb_value  = tb_q[0];
  assign atb_value = tb_q[1];

  tbd_decrementer #(.DATA_W(DATA_W), .UNDERFLOW_TRIG(UNDERFLOW_TRIG)) dec_i (
    .clk       (clk),
    .rst       (rst),
    .adv       (adv),
    .stop_mode (stop_at_zero),
    .wr        (wr_en && (wr_sel == SEL_DEC)),
    .wr_data   (wr_data),
    .ack       (irq_ack),
    .value     (dec_value),
    .irq       (dec_irq)
  );
endmodule

// File: rtl/timebase_decr_chk.sv
module timebase_decr_chk (
  input logic        clk,
  input logic        rst,
  input logic        tick_en,
  input logic        run_en,
  input logic        stop_at_zero,
  input logic        wr_en,
  input logic [2:0]  wr_sel,
  input logic [31:0] wr_data,
  input logic        irq_ack,
  input logic [63:0] tb_value,
  input logic [63:0] atb_value,
  input logic [31:0] dec_value,
  input logic        dec_irq
);
  // R1: state right after reset release
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (tb_value == 64'd0 && atb_value == 64'd0 &&
                    dec_value == 32'hFFFF_FFFF && !dec_irq));

  // R2: primary time base steps by one when counting without a write
  a_r2_tb_step: assert property (@(posedge clk) disable iff (rst)
    (tick_en && run_en && !wr_en) |=> (tb_value == $past(tb_value) + 64'd1));

  // R4: frozen counters hold
  a_r4_freeze: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !wr_en) |=> ($stable(tb_value) && $stable(atb_value) && $stable(dec_value)));

  // R6: wrap-mode expiry
  a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
    (!stop_at_zero && tick_en && run_en && !wr_en && dec_value == 32'd0)
      |=> (dec_value == 32'hFFFF_FFFF && dec_irq));

  // R7: hold-mode stays at zero
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (stop_at_zero && tick_en && run_en && !wr_en && dec_value == 32'd0)
      |=> (dec_value == 32'd0));

  // R8: negative load from non-negative raises interrupt
  a_r8_neg_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 3'd4 && wr_data[31] && !dec_value[31]) |=> dec_irq);

  // R9: pending flag is sticky without acknowledge
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    (dec_irq && !irq_ack) |=> dec_irq);
endmodule

bind timebase_decr_unit timebase_decr_chk chk_i (
  .clk(clk), .rst(rst), .tick_en(tick_en), .run_en(run_en),
  .stop_at_zero(stop_at_zero), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .irq_ack(irq_ack), .tb_value(tb_value),
  .atb_value(atb_value), .dec_value(dec_value), .dec_irq(dec_irq)
);

// File: tb/timebase_decr_unit_tb_top.sv
`timescale 1ns/1ps
module timebase_decr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0, run_en = 1'b0, stop_at_zero = 1'b0;
  logic        wr_en = 1'b0, irq_ack = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [31:0] wr_data = 32'd0;
  logic [63:0] tb_value, atb_value;
  logic [31:0] dec_value;
  logic        dec_irq;

  int tests = 0, fails = 0;
  string req = "R1";

  // behavioural reference state
  longint unsigned m_tb, m_atb;
  int unsigned     m_dec;
  bit              m_irq;

  always #5 clk = ~clk;

  timebase_decr_unit dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .run_en(run_en),
    .stop_at_zero(stop_at_zero), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .irq_ack(irq_ack), .tb_value(tb_value),
    .atb_value(atb_value), .dec_value(dec_value), .dec_irq(dec_irq)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit evt;
    bit go;
    #1;
    if (rst) begin
      m_tb = 0; m_atb = 0; m_dec = 32'hFFFF_FFFF; m_irq = 0;
    end else begin
      go  = tick_en && run_en;
      evt = 0;
      if (wr_en && wr_sel == 3'd0)      m_tb  = (m_tb  & 64'hFFFF_FFFF_0000_0000) | wr_data;
      else if (wr_en && wr_sel == 3'd1) m_tb  = (m_tb  & 64'h0000_0000_FFFF_FFFF) | (longint'(wr_data) << 32);
      else if (go)                      m_tb  = m_tb + 1;
      if (wr_en && wr_sel == 3'd2)      m_atb = (m_atb & 64'hFFFF_FFFF_0000_0000) | wr_data;
      else if (wr_en && wr_sel == 3'd3) m_atb = (m_atb & 64'h0000_0000_FFFF_FFFF) | (longint'(wr_data) << 32);
      else if (go)                      m_atb = m_atb + 1;
      if (wr_en && wr_sel == 3'd4) begin
        if (wr_data[31] && m_dec < 32'h8000_0000) evt = 1;
        m_dec = wr_data;
      end else if (go) begin
        if (stop_at_zero) begin
          if (m_dec == 1) evt = 1;
          if (m_dec != 0) m_dec = m_dec - 1;
        end else begin
          if (m_dec == 0) evt = 1;
          m_dec = m_dec - 1;
        end
      end
      m_irq = evt || (m_irq && !irq_ack);
    end
    check({req, " tb"},  tb_value,  m_tb);
    check({req, " atb"}, atb_value, m_atb);
    check({req, " dec"}, {32'd0, dec_value}, {32'd0, m_dec});
    check({req, " irq"}, {63'd0, dec_irq}, {63'd0, m_irq});
  end

  task automatic step(bit tk, bit rn, bit sz, bit we, logic [2:0] sel,
                      logic [31:0] d, bit ak);
    @(negedge clk);
    tick_en = tk; run_en = rn; stop_at_zero = sz;
    wr_en = we; wr_sel = sel; wr_data = d; irq_ack = ak;
  endtask

  task automatic idle(int n, bit tk, bit rn, bit sz);
    for (int i = 0; i < n; i++) step(tk, rn, sz, 0, 3'd0, 32'd0, 0);
  endtask

  task automatic run_seq;
    logic [63:0] held_tb, held_atb;
    logic [31:0] held_dec;
    logic [15:0] lfsr = 16'hACE1;
    rst = 1'b1;
    idle(3, 0, 0, 0);
    step(0, 0, 0, 0, 3'd0, 0, 0);
    rst = 1'b0;
    @(negedge clk);
    req = "R1";
    check("R1 tb reset", tb_value, 64'd0);
    check("R1 dec reset", {32'd0, dec_value}, 64'hFFFF_FFFF);
    check("R1 irq reset", {63'd0, dec_irq}, 64'd0);

    req = "R2";
    for (int i = 0; i < 20; i++) step(i % 3 != 0, 1, 0, 0, 3'd0, 0, 0);
    step(0, 1, 0, 0, 3'd0, 0, 0);
    @(negedge clk);
    check("R2 tb after 13 ticks", tb_value, 64'd13);

    req = "R3";
    step(0, 1, 0, 1, 3'd1, 32'hDEAD_BEEF, 0);
    step(0, 1, 0, 1, 3'd2, 32'h1234_5678, 0);
    step(0, 1, 0, 1, 3'd3, 32'hCAFE_0001, 0);
    step(0, 1, 0, 1, 3'd0, 32'h0000_0100, 0);
    step(0, 1, 0, 0, 3'd0, 0, 0);
    @(negedge clk);
    check("R3 tb halves", tb_value, 64'hDEAD_BEEF_0000_0100);
    check("R3 atb halves", atb_value, 64'hCAFE_0001_1234_5678);
    held_tb = tb_value; held_atb = atb_value; held_dec = dec_value;
    for (int s = 5; s < 8; s++) step(0, 1, 0, 1, 3'(s), 32'h5555_AAAA, 0);
    step(0, 1, 0, 0, 3'd0, 0, 0);
    @(negedge clk);
    check("R3 unused codes tb", tb_value, held_tb);
    check("R3 unused codes dec", {32'd0, dec_value}, {32'd0, held_dec});

    req = "R5";
    step(1, 1, 0, 1, 3'd0, 32'h0000_0042, 0);
    step(0, 1, 0, 0, 3'd0, 0, 0);
    @(negedge clk);
    check("R5 write over tick", tb_value, 64'hDEAD_BEEF_0000_0042);
    check("R5 atb still ticked", atb_value, held_atb + 64'd1);

    req = "R10";
    step(0, 1, 0, 1, 3'd1, 32'd0, 0);
    step(0, 1, 0, 1, 3'd0, 32'hFFFF_FFFF, 0);
    step(1, 1, 0, 0, 3'd0, 0, 0);
    step(0, 1, 0, 0, 3'd0, 0, 0);
    @(negedge clk);
    check("R10 carry", tb_value, 64'h0000_0001_0000_0000);

    req = "R4";
    held_tb = tb_value; held_atb = atb_value; held_dec = dec_value;
    idle(10, 1, 0, 0);
    @(negedge clk);
    check("R4 frozen tb", tb_value, held_tb);
    check("R4 frozen dec", {32'd0, dec_value}, {32'd0, held_dec});
    idle(4, 1, 1, 0);
    step(0, 1, 0, 0, 3'd0, 0, 0);
    @(negedge clk);
    check("R4 resume atb", atb_value, held_atb + 64'd4);

    req = "R6";
    step(0, 1, 0, 1, 3'd4, 32'd2, 0);
    idle(3, 1, 1, 0);
    step(0, 1, 0, 0, 3'd0, 0, 0);
    @(negedge clk);
    check("R6 wrap value", {32'd0, dec_value}, 64'hFFFF_FFFF);
    check("R6 irq", {63'd0, dec_irq}, 64'd1);

    req = "R9";
    idle(3, 0, 1, 0);
    step(0, 1, 0, 1, 3'd4, 32'd0, 1);   // ack clears
    step(1, 1, 0, 0, 3'd0, 0, 1);       // expiry with ack: set wins
    step(0, 1, 0, 0, 3'd0, 0, 0);
    @(negedge clk);
    check("R9 set beats ack", {63'd0, dec_irq}, 64'd1);
    step(0, 1, 0, 0, 3'd0, 0, 1);
    step(0, 1, 0, 0, 3'd0, 0, 0);
    @(negedge clk);
    check("R9 ack clears", {63'd0, dec_irq}, 64'd0);

    req = "R7";
    step(0, 1, 1, 1, 3'd4, 32'd2, 0);
    idle(6, 1, 1, 1);
    @(negedge clk);
    check("R7 hold at zero", {32'd0, dec_value}, 64'd0);
    check("R7 irq once", {63'd0, dec_irq}, 64'd1);
    step(0, 1, 1, 0, 3'd0, 0, 1);
    idle(4, 1, 1, 1);
    @(negedge clk);
    check("R7 no repeat irq", {63'd0, dec_irq}, 64'd0);

    req = "R8";
    step(0, 1, 0, 1, 3'd4, 32'h8000_0005, 0);
    step(0, 1, 0, 0, 3'd0, 0, 0);
    @(negedge clk);
    check("R8 neg from nonneg", {63'd0, dec_irq}, 64'd1);
    step(0, 1, 0, 0, 3'd0, 0, 1);
    step(0, 1, 0, 1, 3'd4, 32'hF000_0000, 0);
    step(0, 1, 0, 0, 3'd0, 0, 0);
    @(negedge clk);
    check("R8 neg from neg", {63'd0, dec_irq}, 64'd0);

    req = "R2";
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[1] | lfsr[2], lfsr[3] & lfsr[4], lfsr[5] & lfsr[6] & lfsr[7],
           lfsr[10:8], {lfsr[11], 27'd0, lfsr[15:12]}, lfsr[9] & lfsr[2]);
    end
    idle(2, 0, 0, 0);
  endtask

  initial begin
    fork
      run_seq();
      begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule